// File: doc/BRIEF.md
# Video Frame Counter with Lock Control

This block counts the lines of a television frame and keeps the frame phase aligned to an outside picture source. An upstream line timer supplies a one-cycle enable per line. The counter steps once per enable and wraps at the frame length. A three-bit standard select picks a 625-line or a 525-line frame, and a short-frame input removes one line from either.

A two-bit lock mode sets how a frame marker, taken from an external composite sync, is used. In free-running mode the marker is ignored. In fast lock the marker sends the count straight back to line 0. In the two slow modes the block tracks the external frame position in a shadow counter. At each field boundary it closes the gap by one line at a time: it either repeats a line or jumps over one, whichever way round the frame is shorter. One slow mode takes its line steps from an external line reference instead of the internal line timer. A lock flag reports when the marker lands on internal line 0 in consecutive frames.

Top module: `frame_lock_counter`

## Requirements
- R1: While `rst` is high at a clock edge, `line_num` becomes 0 and `frame_start` and `locked` become 0.
- R2: Standard codes 0 to 3 select a 625-line frame and codes 4 to 7 select a 525-line frame. The count runs from 0 to length-1, advances by one on each line step, and wraps to 0.
- R3: With `short_mode` = 1 the frame is one line shorter, so 624 or 524 lines.
- R4: The frame length is latched only when the count lands on 0. A change of `std_sel` or `short_mode` in mid-frame leaves the running frame at its old length.
- R5: With `lock_mode` = 01 the line step is `ext_line_en` and `line_en` is ignored. In the other modes the line step is `line_en` and `ext_line_en` is ignored. With no line step, `line_num` holds its value.
- R6: `frame_start` is high for exactly one cycle: the first cycle in which `line_num` shows 0 after a line step.
- R7: With `lock_mode` = 00 the counter runs freely, `ext_frame` has no effect, and `locked` is 0.
- R8: With `lock_mode` = 11, a marker on a line step sets the count to 0 on that step.
- R9: In slow lock (`lock_mode` 01 or 10), after the first marker the block tracks the external position. The external position is 0 on a marker step and advances and wraps like the count otherwise. A correction happens on a step whose normal next count is 0 or length/2 (rounded down), if that next count differs from the external position and the previous step was not a correction. With d = (internal next - external) mod length, the count repeats its line when 2d <= length and otherwise advances by two.
- R10: `locked` is set on a marker step whose normal next count is 0, provided the previous marker step also met that condition. Any marker step that does not meet it clears `locked`.
- R11: `ext_frame` counts only in a cycle that also carries a line step. Otherwise it changes neither the count nor the lock state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| line_en | input | 1 | Line step from the internal line timer |
| ext_line_en | input | 1 | Line step from the external line reference |
| ext_frame | input | 1 | External frame marker, valid only with a line step |
| std_sel | input | 3 | Standard select; bit 2 = 1 picks 525 lines |
| short_mode | input | 1 | Removes one line from the frame |
| lock_mode | input | 2 | 00 free, 01 slow with external line step, 10 slow, 11 fast |
| line_num | output | 10 | Current line number |
| frame_start | output | 1 | One-cycle strobe when line 0 begins |
| locked | output | 1 | Frame phase matches the external marker |

## Verification
Two events can fall on the same line step. A field-boundary slip correction can meet an arriving marker. A forced or corrected landing on line 0 can meet a pending change of frame length. The bench provokes both cases with directed marker phases offset a few lines either side of the wrap, and with random marker timing while the standard and short-frame inputs toggle. A bench model that updates line by line judges every cycle. It predicts the count, the strobe and the lock flag, so a repeat, a jump or a length latch taken in the wrong step shows up as a mismatch.

// File: rtl/frame_lock_counter.sv
module frame_lock_counter #(
  parameter int LW      = 10,
  parameter int LINES_A = 625,
  parameter int LINES_B = 525
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          line_en,
  input  logic          ext_line_en,
  input  logic          ext_frame,
  input  logic [2:0]    std_sel,
  input  logic          short_mode,
  input  logic [1:0]    lock_mode,
  output logic [LW-1:0] line_num,
  output logic          frame_start,
  output logic          locked
);

  localparam logic [LW-1:0] LEN_A = LW'(LINES_A);
  localparam logic [LW-1:0] LEN_B = LW'(LINES_B);

  logic [LW-1:0] cnt, pos, len_q;
  logic          seen, hit, fixed_last;

  logic [LW-1:0] len_in, half, nn, pn, skip_v, next_c;
  logic [LW:0]   diff;
  logic          step, mk, slow, fast, fix, hold_dir;

  assign len_in   = (std_sel[2] ? LEN_B : LEN_A) - LW'(short_mode);
  assign step     = (lock_mode == 2'b01) ? ext_line_en : line_en;
  assign mk       = step & ext_frame & (lock_mode != 2'b00);
  assign slow     = (lock_mode == 2'b01) || (lock_mode == 2'b10);
  assign fast     = (lock_mode == 2'b11);
  assign half     = len_q >> 1;
  assign nn       = (cnt >= len_q - 1'b1) ? '0 : cnt + 1'b1;
  assign pn       = mk ? '0 : ((pos >= len_q - 1'b1) ? '0 : pos + 1'b1);
  assign diff     = (nn >= pn) ? {1'b0, nn - pn} : {1'b0, nn} + {1'b0, len_q} - {1'b0, pn};
  assign hold_dir = ({diff, 1'b0} <= {1'b0, len_q, 1'b0} >> 1) ? 1'b1 : 1'b0;
  assign skip_v   = (nn >= len_q - 1'b1) ? '0 : nn + 1'b1;
  assign fix      = slow & (seen | mk) & ~fixed_last & ((nn == '0) | (nn == half)) & (nn != pn);

  always_comb begin
    if (fast && mk)   next_c = '0;
    else if (fix)     next_c = hold_dir ? cnt : skip_v;
    else              next_c = nn;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      pos         <= '0;
      len_q       <= len_in;
      seen        <= 1'b0;
      hit         <= 1'b0;
      fixed_last  <= 1'b0;
      locked      <= 1'b0;
      frame_start <= 1'b0;
    end else begin
      frame_start <= step && (next_c == '0);
      if (step) begin
        cnt        <= next_c;
        fixed_last <= fix;
        if (next_c == '0) len_q <= len_in;
        if (lock_mode != 2'b00) begin
          pos <= pn;
          if (mk) seen <= 1'b1;
        end
      end
      if (lock_mode == 2'b00) begin
        hit    <= 1'b0;
        locked <= 1'b0;
      end else if (mk) begin
        if (nn == '0) begin
          locked <= hit;
          hit    <= 1'b1;
        end else begin
          hit    <= 1'b0;
          locked <= 1'b0;
        end
      end
    end
  end

  assign line_num = cnt;

  p_reset_r1: assert property (@(posedge clk) rst |=> (line_num == '0 && !frame_start && !locked));

  p_line_max_r2: assert property (@(posedge clk) disable iff (rst) line_num < LEN_A);

  p_len_latch_r4: assert property (@(posedge clk) disable iff (rst)
    (line_num != '0) |-> $stable(len_q));

  p_idle_r5: assert property (@(posedge clk) disable iff (rst)
    !((lock_mode == 2'b01) ? ext_line_en : line_en) |=> $stable(line_num));

  p_strobe_r6: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> line_num == '0);

  p_free_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_mode == 2'b00 && line_en && line_num < len_q - 1'b1) |=> line_num == $past(line_num) + 1'b1);

  p_free_unlocked_r7: assert property (@(posedge clk) disable iff (rst)
    (lock_mode == 2'b00) |=> !locked);

  p_fast_r8: assert property (@(posedge clk) disable iff (rst)
    (lock_mode == 2'b11 && line_en && ext_frame) |=> line_num == '0);

  p_slip_r9: assert property (@(posedge clk) disable iff (rst)
    (slow && step && line_num < len_q - 2'd2) |=>
      (line_num == $past(line_num) || line_num == $past(line_num) + 1'b1 || line_num == $past(line_num) + 2'd2));

  p_unlock_r10: assert property (@(posedge clk) disable iff (rst)
    (mk && line_num != len_q - 1'b1) |=> !locked);

endmodule

// File: tb/sim_frame_lock_counter.sv
module sim_frame_lock_counter;
  logic       clk = 0, rst = 1;
  logic       line_en = 0, ext_line_en = 0, ext_frame = 0, short_mode = 0;
  logic [2:0] std_sel = 0;
  logic [1:0] lock_mode = 0;
  logic [9:0] line_num;
  logic       frame_start, locked;

  int checks = 0, errors = 0;
  int m_cnt, m_len, m_pos, m_seen, m_hit, m_lock, m_fl, m_fs;
  bit done = 0;

  frame_lock_counter u0 (.clk(clk), .rst(rst), .line_en(line_en), .ext_line_en(ext_line_en),
    .ext_frame(ext_frame), .std_sel(std_sel), .short_mode(short_mode), .lock_mode(lock_mode),
    .line_num(line_num), .frame_start(frame_start), .locked(locked));

  always #2 clk = ~clk;

  function automatic int len_of(logic [2:0] s, logic sh);
    return (s[2] ? 525 : 625) - int'(sh);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic model(bit le, bit xle, bit ef);
    int stp, mk, nn, pn, half, diff, fix, nxt, skv, md;
    md = int'(lock_mode);
    stp = (md == 1) ? xle : le;
    m_fs = 0;
    if (stp) begin
      mk   = (ef && md != 0);
      nn   = (m_cnt >= m_len - 1) ? 0 : m_cnt + 1;
      pn   = mk ? 0 : ((m_pos >= m_len - 1) ? 0 : m_pos + 1);
      half = m_len / 2;
      diff = (nn >= pn) ? nn - pn : nn + m_len - pn;
      fix  = ((md == 1 || md == 2) && (m_seen || mk) && !m_fl && (nn == 0 || nn == half) && nn != pn);
      skv  = (nn >= m_len - 1) ? 0 : nn + 1;
      if (md == 3 && mk) nxt = 0;
      else if (fix) nxt = (2 * diff <= m_len) ? m_cnt : skv;
      else nxt = nn;
      if (md != 0 && mk) begin
        if (nn == 0) begin m_lock = m_hit; m_hit = 1; end
        else begin m_hit = 0; m_lock = 0; end
      end
      if (md != 0) begin m_pos = pn; if (mk) m_seen = 1; end
      m_fl  = fix;
      m_cnt = nxt;
      if (nxt == 0) m_len = len_of(std_sel, short_mode);
      m_fs = (nxt == 0);
    end
    if (md == 0) begin m_hit = 0; m_lock = 0; end
  endtask

  task automatic tick(bit le, bit xle, bit ef);
    @(negedge clk);
    line_en = le; ext_line_en = xle; ext_frame = ef;
    @(posedge clk);
    model(le, xle, ef);
    #1;
    chk("R9 line_num", int'(line_num), m_cnt);
    chk("R6 frame_start", int'(frame_start), m_fs);
    chk("R10 locked", int'(locked), m_lock);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) tick(1, 1, 0);
  endtask

  task automatic run_ext(int n, int first, int period);
    for (int i = 0; i < n; i++) tick(1, 1, (i >= first) && ((i - first) % period == 0));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seed_v;
    seed_v = $urandom(32'h5a17);
    repeat (3) @(posedge clk);
    #1;
    chk("R1 line", int'(line_num), 0);
    chk("R1 strobe", int'(frame_start), 0);
    chk("R1 lock", int'(locked), 0);
    @(negedge clk); rst = 0;
    m_cnt = 0; m_len = 625; m_pos = 0; m_seen = 0; m_hit = 0; m_lock = 0; m_fl = 0; m_fs = 0;

    run(624);
    chk("R2 last line 625", int'(line_num), 624);
    run(1);
    chk("R2 wrap", int'(line_num), 0);
    chk("R6 strobe at 0", int'(frame_start), 1);
    run(1);
    chk("R6 strobe one cycle", int'(frame_start), 0);
    run(99);
    tick(1, 1, 1);
    chk("R7 marker ignored", int'(line_num), 101);
    chk("R7 unlocked", int'(locked), 0);

    short_mode = 1;
    run(523);
    chk("R4 old length kept", int'(line_num), 624);
    run(1);
    run(623);
    chk("R3 short last line", int'(line_num), 623);
    std_sel = 3'd4; short_mode = 0;
    run(1);
    chk("R3 short wrap", int'(line_num), 0);
    run(524);
    chk("R2 last line 525", int'(line_num), 524);
    run(1);

    lock_mode = 2'b01;
    for (int i = 0; i < 5; i++) tick(1, 0, 0);
    chk("R5 line_en ignored", int'(line_num), 0);
    tick(0, 1, 0);
    chk("R5 external step", int'(line_num), 1);

    lock_mode = 2'b11; std_sel = 3'd1;
    run(199);
    chk("R8 before marker", int'(line_num), 200);
    tick(1, 1, 1);
    chk("R8 forced to 0", int'(line_num), 0);
    tick(0, 0, 1);
    chk("R11 marker without step", int'(line_num), 0);
    chk("R11 lock untouched", int'(locked), 0);
    run(624); tick(1, 1, 1);
    chk("R10 first match", int'(locked), 0);
    run(624); tick(1, 1, 1);
    chk("R10 second match", int'(locked), 1);
    run(10); tick(1, 1, 1);
    chk("R10 mismatch clears", int'(locked), 0);

    lock_mode = 2'b10;
    run_ext(625 * 8, 621, 625);
    chk("R9 slow lock from behind", int'(locked), 1);
    run_ext(625 * 10, 5, 625);
    chk("R9 slow lock from ahead", int'(locked), 1);

    for (int i = 0; i < 40000; i++) begin
      if ($urandom % 3000 == 0) lock_mode = 2'($urandom);
      if ($urandom % 5000 == 0) std_sel = 3'($urandom);
      if ($urandom % 5000 == 0) short_mode = 1'($urandom);
      tick(($urandom % 4) != 0, ($urandom % 4) != 0, ($urandom % 500) == 0);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule